// File: doc/BRIEF.md
# ADC Read-During-Conversion Sequencer

This block sits on the host side of a parallel-output, simultaneous-sampling analog-to-digital converter. It starts a conversion with one pulse on the converter's start line. It then collects the results while the converter is still working through its channels. Each time the converter's per-result ready strobe falls, the sequencer drives the read and chip-select lines low for a set number of clocks. It captures the data bus on the last of those cycles and presents the word on a one-cycle valid stream, together with a channel index.

The sequence ends at the read in which the converter's last-result flag is low, or after a configured number of reads, whichever comes first. After that the sequencer keeps the bus idle for a configurable quiet time before another conversion may start, so that bus activity cannot disturb the converter's acquisition. The ready strobe and the last-result flag are asynchronous to the system clock and pass through synchronizer chains. If the ready strobe fails to fall within a fixed number of clocks, the sequence is abandoned and an error flag is raised.

Top module: `adc_rdc_ctrl`

## Requirements
- R1: While reset is held (synchronous, active low), the conversion start line, `smp_valid`, `smp_last`, `busy` and `err_timeout` are 0, and the read and select lines are 1.
- R2: When `start` is 1 at a clock edge while the block is idle, `adc_conv_go` is 1 for exactly the next cycle and `busy` becomes 1. A `start` held high while busy causes no further conversion start until the block is idle again.
- R3: A read begins only after a falling edge of the ready strobe. `adc_read_n` goes low at the second clock edge after the first edge that samples `adc_done_n` low while the block waits for a result.
- R4: Each read holds `adc_read_n` low for max(`cfg_rd_len`,1) consecutive cycles. `adc_sel_n` equals `adc_read_n` in every cycle.
- R5: `adc_data` is captured at the clock edge that ends a read. In the following cycle `smp_valid` is 1 for one cycle with that word on `smp_data`. `smp_chan` is 0 for the first read of a sequence and rises by 1 with each later read.
- R6: The read in which the synchronized `adc_final_n` is low, or the read with index equal to `cfg_nchan` (the channel count minus one), is the last of the sequence. It carries `smp_last`=1, and no more reads follow.
- R7: After the last read, at least max(`cfg_quiet_len`,1)+1 cycles with `adc_read_n` high and `adc_conv_go` low pass before the next conversion start. With `start` held high, the number is exactly that.
- R8: If the block has waited WAIT_LIMIT cycles without a falling ready strobe, it abandons the sequence, sets `err_timeout` to 1 and runs the quiet time. The flag stays 1 until the next accepted `start`, which clears it.
- R9: Ready-strobe falls that occur after the sequence has ended (during the quiet time or while idle) cause no read and no output word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Request a conversion sequence |
| cfg_nchan | input | CHW | Channel count minus one; read limit per sequence |
| cfg_rd_len | input | RDW | Read pulse length in cycles (0 acts as 1) |
| cfg_quiet_len | input | QW | Quiet time in cycles before a restart (0 acts as 1) |
| adc_done_n | input | 1 | Converter per-result ready strobe, active low, asynchronous |
| adc_final_n | input | 1 | Converter last-result flag, active low, asynchronous |
| adc_data | input | DW | Converter parallel data bus |
| adc_conv_go | output | 1 | Conversion start pulse to the converter |
| adc_read_n | output | 1 | Read strobe, active low |
| adc_sel_n | output | 1 | Chip select, active low, same as the read strobe |
| smp_valid | output | 1 | Output word valid, one cycle per read |
| smp_data | output | DW | Captured result |
| smp_chan | output | CHW | Channel index of the captured result |
| smp_last | output | 1 | Marks the final word of a sequence |
| busy | output | 1 | A sequence or quiet time is in progress |
| err_timeout | output | 1 | Last sequence was abandoned for lack of a ready strobe |

## Verification
The bench builds the block with WAIT_LIMIT lowered to 40, so that the abandon path can be reached and timed to the cycle within a few hundred clocks. Both the fully silent case and the case where the converter stops after one result are covered. The default 4-bit read length and 8-bit quiet length are kept. This covers the zero-means-one clamp, a long 7-cycle read and the exact restart gap with `start` held high. The 3-bit channel field lets the bench set a read limit of two while the emulated converter delivers five results, so that the limit ends the sequence and the late strobes land in the quiet and idle phases.

// File: rtl/adc_rdc_pkg.sv
// Shared types for the ADC read-during-conversion sequencer.
// Assumes: nothing beyond the 1800-2017 language.
package adc_rdc_pkg;

    // Sequencer phases: idle, start pulse, wait for a result, read pulse, bus quiet
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_START = 3'd1,
        ST_WAIT  = 3'd2,
        ST_READ  = 3'd3,
        ST_QUIET = 3'd4
    } seq_state_t;

    // Smallest synchronizer chain accepted for the asynchronous converter strobes
    localparam int SYNC_MIN = 2;

endpackage

// File: rtl/adc_rdc_sync.sv
// Multi-bit synchronizer: one independent flop chain per bit.
// Assumes: each bit is a slow level signal whose value alone matters; the
// bits are not a coherent bus. Chains reset to 1 (inactive for active-low lines).
module adc_rdc_sync #(
    parameter int W      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out
);

    for (genvar b = 0; b < W; b++) begin : g_bit
        logic [STAGES-1:0] chain;

        // shift the raw input into a per-bit flop chain
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                chain <= '1;
            end else begin
                chain <= {chain[STAGES-2:0], async_in[b]};
            end
        end

        assign sync_out[b] = chain[STAGES-1];
    end

endmodule

// File: rtl/adc_rdc_seq.sv
// Conversion sequencer: start pulse, wait for each ready-strobe fall, timed
// read pulse, end-of-sequence decision, timeout abort, and quiet time.
// Assumes: done_lvl and final_lvl are already synchronized. Strobe falls that
// arrive while a read is still running are not queued (the converter spaces its
// results further apart than one read). Configuration is stable during a sequence.
module adc_rdc_seq
    import adc_rdc_pkg::*;
#(
    parameter int CHW        = 3,
    parameter int RDW        = 4,
    parameter int QW         = 8,
    parameter int WAIT_LIMIT = 256
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    input  logic [CHW-1:0] cfg_nchan,
    input  logic [RDW-1:0] cfg_rd_len,
    input  logic [QW-1:0]  cfg_quiet_len,
    input  logic           done_lvl,
    input  logic           final_lvl,
    output seq_state_t     state,
    output logic           cap_en,
    output logic           cap_last,
    output logic [CHW-1:0] cap_idx,
    output logic           err_timeout
);

    localparam int CW = (RDW > QW) ? RDW : QW;
    localparam int TW = $clog2(WAIT_LIMIT + 1);
    localparam logic [TW-1:0] TO_LAST = TW'(WAIT_LIMIT - 1);

    logic [CW-1:0]  ph_cnt;
    logic [TW-1:0]  to_cnt;
    logic [CHW-1:0] idx;
    logic           done_prev;
    logic           done_fell;
    logic [CW-1:0]  rd_last;
    logic [CW-1:0]  q_last;
    logic           rd_done;
    logic           seq_last;

    // terminal counts for the read pulse and quiet time, zero clamped to one cycle
    always_comb begin
        rd_last  = (cfg_rd_len == '0)    ? '0 : CW'(cfg_rd_len - 1'b1);
        q_last   = (cfg_quiet_len == '0) ? '0 : CW'(cfg_quiet_len - 1'b1);
        rd_done  = (state == ST_READ) && (ph_cnt == rd_last);
        seq_last = !final_lvl || (idx == cfg_nchan);
    end

    assign done_fell = done_prev && !done_lvl;
    assign cap_en    = rd_done;
    assign cap_last  = seq_last;
    assign cap_idx   = idx;

    // remember the previous synchronized ready level for fall detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_prev <= 1'b1;
        end else begin
            done_prev <= done_lvl;
        end
    end

    // phase sequencing with its cycle counters, read index and abort flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state       <= ST_IDLE;
            ph_cnt      <= '0;
            to_cnt      <= '0;
            idx         <= '0;
            err_timeout <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        state       <= ST_START;
                        idx         <= '0;
                        err_timeout <= 1'b0;
                    end
                end
                ST_START: begin
                    state  <= ST_WAIT;
                    to_cnt <= '0;
                end
                ST_WAIT: begin
                    if (done_fell) begin
                        state  <= ST_READ;
                        ph_cnt <= '0;
                    end else if (to_cnt == TO_LAST) begin
                        state       <= ST_QUIET;
                        ph_cnt      <= '0;
                        err_timeout <= 1'b1;
                    end else begin
                        to_cnt <= to_cnt + 1'b1;
                    end
                end
                ST_READ: begin
                    if (rd_done) begin
                        idx    <= idx + 1'b1;
                        to_cnt <= '0;
                        ph_cnt <= '0;
                        state  <= seq_last ? ST_QUIET : ST_WAIT;
                    end else begin
                        ph_cnt <= ph_cnt + 1'b1;
                    end
                end
                ST_QUIET: begin
                    if (ph_cnt == q_last) begin
                        state <= ST_IDLE;
                    end else begin
                        ph_cnt <= ph_cnt + 1'b1;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R2: the start phase is entered only from idle on a request
    p_start_from_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_START) |-> ($past(state) == ST_IDLE && $past(start)));

    // R3: a read is entered from waiting only on a detected strobe fall
    p_read_needs_edge_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_READ && $past(state) == ST_WAIT) |-> $past(done_fell));

    // R8: the abort flag rises only out of the waiting phase
    p_err_from_wait_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_timeout) |-> ($past(state) == ST_WAIT));

endmodule

// File: rtl/adc_rdc_capture.sv
// Output register stage: holds the captured word, its channel index and the
// last-word mark, and raises a one-cycle valid.
// Assumes: cap_en is a single-cycle strobe at the end of each read.
module adc_rdc_capture #(
    parameter int DW  = 14,
    parameter int CHW = 3
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           cap_en,
    input  logic [DW-1:0]  cap_data,
    input  logic [CHW-1:0] cap_idx,
    input  logic           cap_last,
    output logic           smp_valid,
    output logic [DW-1:0]  smp_data,
    output logic [CHW-1:0] smp_chan,
    output logic           smp_last
);

    // register the bus word and its tags when a read completes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            smp_valid <= 1'b0;
            smp_data  <= '0;
            smp_chan  <= '0;
            smp_last  <= 1'b0;
        end else begin
            smp_valid <= cap_en;
            if (cap_en) begin
                smp_data <= cap_data;
                smp_chan <= cap_idx;
                smp_last <= cap_last;
            end
        end
    end

    // R5: each word is presented for exactly one cycle
    p_valid_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        smp_valid |=> !smp_valid);

endmodule

// File: rtl/adc_rdc_ctrl.sv
// Top of the ADC read-during-conversion sequencer: synchronizes the converter
// strobes, runs the sequencer and registers output words.
// Assumes: converter strobes are asynchronous and active low; the data bus is
// stable while the read line is low; chip select may mirror the read line.
module adc_rdc_ctrl
    import adc_rdc_pkg::*;
#(
    parameter int DW          = 14,
    parameter int CHW         = 3,
    parameter int RDW         = 4,
    parameter int QW          = 8,
    parameter int WAIT_LIMIT  = 256,
    parameter int SYNC_STAGES = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    input  logic [CHW-1:0] cfg_nchan,
    input  logic [RDW-1:0] cfg_rd_len,
    input  logic [QW-1:0]  cfg_quiet_len,
    input  logic           adc_done_n,
    input  logic           adc_final_n,
    input  logic [DW-1:0]  adc_data,
    output logic           adc_conv_go,
    output logic           adc_read_n,
    output logic           adc_sel_n,
    output logic           smp_valid,
    output logic [DW-1:0]  smp_data,
    output logic [CHW-1:0] smp_chan,
    output logic           smp_last,
    output logic           busy,
    output logic           err_timeout
);

    localparam int NSTG = (SYNC_STAGES < SYNC_MIN) ? SYNC_MIN : SYNC_STAGES;

    logic [1:0]     strobe_sync;
    seq_state_t     state;
    logic           cap_en;
    logic           cap_last;
    logic [CHW-1:0] cap_idx;

    adc_rdc_sync #(
        .W      (2),
        .STAGES (NSTG)
    ) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in ({adc_final_n, adc_done_n}),
        .sync_out (strobe_sync)
    );

    adc_rdc_seq #(
        .CHW        (CHW),
        .RDW        (RDW),
        .QW         (QW),
        .WAIT_LIMIT (WAIT_LIMIT)
    ) u_seq (
        .clk           (clk),
        .rst_n         (rst_n),
        .start         (start),
        .cfg_nchan     (cfg_nchan),
        .cfg_rd_len    (cfg_rd_len),
        .cfg_quiet_len (cfg_quiet_len),
        .done_lvl      (strobe_sync[0]),
        .final_lvl     (strobe_sync[1]),
        .state         (state),
        .cap_en        (cap_en),
        .cap_last      (cap_last),
        .cap_idx       (cap_idx),
        .err_timeout   (err_timeout)
    );

    adc_rdc_capture #(
        .DW  (DW),
        .CHW (CHW)
    ) u_cap (
        .clk       (clk),
        .rst_n     (rst_n),
        .cap_en    (cap_en),
        .cap_data  (adc_data),
        .cap_idx   (cap_idx),
        .cap_last  (cap_last),
        .smp_valid (smp_valid),
        .smp_data  (smp_data),
        .smp_chan  (smp_chan),
        .smp_last  (smp_last)
    );

    // converter-side strobes decoded from the registered phase
    assign adc_conv_go = (state == ST_START);
    assign adc_read_n  = (state != ST_READ);
    assign adc_sel_n   = adc_read_n;
    assign busy        = (state != ST_IDLE);

    // R2: the conversion start is a single-cycle pulse
    p_go_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        adc_conv_go |=> !adc_conv_go);

    // R4: a read longer than one cycle keeps the line low after its first cycle
    p_read_width_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(adc_read_n) && (cfg_rd_len > 1)) |=> !adc_read_n);

    // R5: an output word follows a cycle in which the read line was low
    p_valid_after_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
        smp_valid |-> !$past(adc_read_n));

    // R7: a conversion never starts straight out of a read cycle
    p_no_go_after_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(adc_conv_go) |-> $past(adc_read_n));

endmodule

// File: tb/sim_adc_rdc_ctrl.sv
module sim_adc_rdc_ctrl;

    localparam int DW  = 14;
    localparam int CHW = 3;
    localparam int RDW = 4;
    localparam int QW  = 8;
    localparam int WL  = 40;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           start = 1'b0;
    logic [CHW-1:0] cfg_nchan = '0;
    logic [RDW-1:0] cfg_rd_len = '0;
    logic [QW-1:0]  cfg_quiet_len = '0;
    logic           adc_done_n = 1'b1;
    logic           adc_final_n = 1'b1;
    logic [DW-1:0]  adc_data = '0;
    logic           adc_conv_go, adc_read_n, adc_sel_n;
    logic           smp_valid, smp_last, busy, err_timeout;
    logic [DW-1:0]  smp_data;
    logic [CHW-1:0] smp_chan;

    int n_total = 0;
    int n_bad   = 0;
    bit cmp_on  = 1'b0;

    adc_rdc_ctrl #(
        .DW(DW), .CHW(CHW), .RDW(RDW), .QW(QW), .WAIT_LIMIT(WL), .SYNC_STAGES(2)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .cfg_nchan(cfg_nchan),
        .cfg_rd_len(cfg_rd_len), .cfg_quiet_len(cfg_quiet_len),
        .adc_done_n(adc_done_n), .adc_final_n(adc_final_n), .adc_data(adc_data),
        .adc_conv_go(adc_conv_go), .adc_read_n(adc_read_n), .adc_sel_n(adc_sel_n),
        .smp_valid(smp_valid), .smp_data(smp_data), .smp_chan(smp_chan),
        .smp_last(smp_last), .busy(busy), .err_timeout(err_timeout)
    );

    always #2 clk = ~clk;

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_total++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] pat(input int s, input int k);
        return DW'((s * 613 + k * 2897 + 77) % 16384);
    endfunction

    // ---------------- converter emulator (drives at negedge) ----------------
    int a_nres = 1, a_stop = 8, a_dly = 6, a_gap = 8;
    int a_t = 0, a_seq = 0;
    bit a_run = 1'b0;

    always @(negedge clk) begin
        if (!rst_n) begin
            adc_done_n  <= 1'b1;
            adc_final_n <= 1'b1;
            a_run = 1'b0;
        end else if (adc_conv_go) begin
            a_run = 1'b1;
            a_t = 0;
            a_seq++;
            adc_done_n  <= 1'b1;
            adc_final_n <= 1'b1;
        end else if (a_run) begin
            int pos, k, ph;
            a_t++;
            pos = a_t - a_dly;
            if (pos >= 0) begin
                k  = pos / a_gap;
                ph = pos % a_gap;
                if (k >= a_nres || k >= a_stop) begin
                    adc_done_n <= 1'b1;
                    a_run = 1'b0;
                end else begin
                    adc_done_n <= (ph < 2) ? 1'b0 : 1'b1;
                    if (ph == 0) adc_data <= pat(a_seq, k);
                    if (k == a_nres - 1) adc_final_n <= 1'b0;
                end
            end
        end
    end

    // ---------------- behavioural reference model (posedge) ----------------
    int m_st = 0, m_cnt = 0, m_to = 0, m_idx = 0, m_chan = 0;
    bit m_err = 0, m_v = 0, m_last = 0;
    logic [DW-1:0] m_data = '0;
    logic [2:0] m_sh = 3'b111;  // [0] first sync flop, [1] second, [2] previous
    logic [1:0] m_lh = 2'b11;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_st = 0; m_cnt = 0; m_to = 0; m_idx = 0;
            m_err = 0; m_v = 0; m_last = 0; m_chan = 0; m_data = '0;
            m_sh = 3'b111; m_lh = 2'b11;
        end else begin
            bit fall, fin;
            int rd1, q1;
            fall = (m_sh[1] == 1'b0) && (m_sh[2] == 1'b1);
            fin  = m_lh[1];
            rd1  = (cfg_rd_len == 0) ? 0 : int'(cfg_rd_len) - 1;
            q1   = (cfg_quiet_len == 0) ? 0 : int'(cfg_quiet_len) - 1;
            m_v  = 0;
            case (m_st)
                0: if (start) begin m_st = 1; m_err = 0; m_idx = 0; end
                1: begin m_st = 2; m_to = 0; end
                2: begin
                    if (fall) begin m_st = 3; m_cnt = 0; end
                    else if (m_to == WL - 1) begin m_st = 4; m_cnt = 0; m_err = 1; end
                    else m_to++;
                end
                3: begin
                    if (m_cnt == rd1) begin
                        m_v = 1; m_data = adc_data; m_chan = m_idx;
                        m_last = (fin == 1'b0) || (m_idx == int'(cfg_nchan));
                        m_idx = (m_idx + 1) % 8;
                        m_to = 0; m_cnt = 0;
                        m_st = m_last ? 4 : 2;
                    end else m_cnt++;
                end
                default: begin
                    if (m_cnt == q1) m_st = 0; else m_cnt++;
                end
            endcase
            m_sh = {m_sh[1], m_sh[0], adc_done_n};
            m_lh = {m_lh[0], adc_final_n};
        end
    end

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n && cmp_on) begin
            chk(adc_conv_go === (m_st == 1), "R2 conv_go vs model", adc_conv_go, (m_st == 1));
            chk(adc_read_n === (m_st != 3), "R3 read_n vs model", adc_read_n, (m_st != 3));
            chk(adc_sel_n === adc_read_n, "R4 sel_n equals read_n", adc_sel_n, adc_read_n);
            chk(busy === (m_st != 0), "R2 busy vs model", busy, (m_st != 0));
            chk(err_timeout === m_err, "R8 err_timeout vs model", err_timeout, m_err);
            chk(smp_valid === m_v, "R5 smp_valid vs model", smp_valid, m_v);
            if (m_v && smp_valid) begin
                chk(smp_data === m_data, "R5 smp_data", smp_data, m_data);
                chk(smp_chan === CHW'(m_chan), "R5 smp_chan", smp_chan, m_chan);
                chk(smp_last === m_last, "R6 smp_last", smp_last, m_last);
            end
        end
    end

    // ---------------- port monitor (negedge) ----------------
    int n_go = 0, n_valid = 0, n_reads = 0, n_busy = 0;
    int rd_run = 0, w_min = 99, w_max = 0, q_run = 0, last_gap = -1;
    bit go_prev = 0, rd_prev = 1;

    always @(negedge clk) begin
        if (rst_n) begin
            if (adc_conv_go && !go_prev) begin
                n_go++;
                last_gap = q_run;
            end
            if (!adc_read_n) q_run = 0;
            else if (!adc_conv_go) q_run++;
            if (!adc_read_n) rd_run++;
            else if (!rd_prev) begin
                n_reads++;
                if (rd_run < w_min) w_min = rd_run;
                if (rd_run > w_max) w_max = rd_run;
                rd_run = 0;
            end
            if (smp_valid) n_valid++;
            if (busy) n_busy++;
            go_prev = adc_conv_go;
            rd_prev = adc_read_n;
        end
    end

    task automatic clr_mon();
        @(posedge clk);
        n_go = 0; n_valid = 0; n_reads = 0; n_busy = 0;
        w_min = 99; w_max = 0;
        @(negedge clk);
    endtask

    task automatic wait_idle(input int tail);
        for (int i = 0; i < 3000 && busy; i++) @(negedge clk);
        repeat (tail) @(negedge clk);
    endtask

    task automatic run_seq(input int nres, input int stop, input int gap);
        a_nres = nres; a_stop = stop; a_gap = gap;
        clr_mon();
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_idle(60);
    endtask

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        n_total++; n_bad++;
        $display("FAIL watchdog act=%0d exp=%0d", 1, 0);
        $display("test done: total=%0d bad=%0d", n_total, n_bad);
        $finish;
    end

    initial begin
        cfg_nchan = 3'd7; cfg_rd_len = 4'd2; cfg_quiet_len = 8'd5;
        repeat (4) @(negedge clk);
        // R1: reset state
        chk(adc_conv_go === 1'b0, "R1 conv_go in reset", adc_conv_go, 0);
        chk(adc_read_n === 1'b1, "R1 read_n in reset", adc_read_n, 1);
        chk(adc_sel_n === 1'b1, "R1 sel_n in reset", adc_sel_n, 1);
        chk(smp_valid === 1'b0, "R1 smp_valid in reset", smp_valid, 0);
        chk(smp_last === 1'b0, "R1 smp_last in reset", smp_last, 0);
        chk(busy === 1'b0, "R1 busy in reset", busy, 0);
        chk(err_timeout === 1'b0, "R1 err in reset", err_timeout, 0);
        rst_n = 1'b1;
        cmp_on = 1'b1;
        repeat (3) @(negedge clk);

        // three results, final flag on the third (R5, R6)
        run_seq(3, 8, 8);
        chk(n_valid == 3, "R6 words for three results", n_valid, 3);
        chk(n_go == 1, "R2 one start pulse", n_go, 1);
        chk(w_min == 2 && w_max == 2, "R4 read width 2", w_max, 2);

        // zero read length acts as one cycle, zero quiet (R4, R7)
        cfg_rd_len = 4'd0; cfg_quiet_len = 8'd0;
        run_seq(1, 8, 7);
        chk(n_valid == 1, "R6 single result", n_valid, 1);
        chk(w_min == 1 && w_max == 1, "R4 zero length reads one cycle", w_max, 1);

        // channel limit of two while converter delivers five (R6, R9)
        cfg_rd_len = 4'd2; cfg_quiet_len = 8'd3; cfg_nchan = 3'd1;
        run_seq(5, 8, 8);
        chk(n_valid == 2, "R6 read limit stops sequence", n_valid, 2);
        chk(n_reads == 2, "R9 late strobes cause no read", n_reads, 2);

        // start held high: one start per sequence, exact quiet gap (R2, R7)
        cfg_nchan = 3'd7; cfg_quiet_len = 8'd5;
        a_nres = 2; a_stop = 8; a_gap = 8;
        clr_mon();
        start = 1'b1;
        begin
            int seen = 0;
            bit gp = 0;
            for (int i = 0; i < 2000 && seen < 2; i++) begin
                @(negedge clk);
                if (adc_conv_go && !gp) seen++;
                gp = adc_conv_go;
            end
        end
        start = 1'b0;
        wait_idle(60);
        chk(n_go == 2, "R2 held start gives one start per sequence", n_go, 2);
        chk(last_gap == 6, "R7 quiet gap with held start", last_gap, 6);
        chk(n_valid == 4, "R5 words over two sequences", n_valid, 4);

        // silent converter: abort after WAIT_LIMIT (R8)
        cfg_quiet_len = 8'd3;
        run_seq(3, 0, 8);
        chk(err_timeout === 1'b1, "R8 error after silent wait", err_timeout, 1);
        chk(n_valid == 0, "R8 no words on abort", n_valid, 0);
        chk(n_busy == 1 + WL + 3, "R8 busy length on abort", n_busy, 1 + WL + 3);

        // next accepted start clears the error (R8)
        run_seq(1, 8, 8);
        chk(err_timeout === 1'b0, "R8 error cleared by start", err_timeout, 0);
        chk(n_valid == 1, "R5 word after recovery", n_valid, 1);

        // converter stops after one of three results (R8)
        run_seq(3, 1, 8);
        chk(n_valid == 1, "R8 one word before abort", n_valid, 1);
        chk(err_timeout === 1'b1, "R8 error mid sequence", err_timeout, 1);

        // long read of seven cycles, four results (R4, R3)
        cfg_rd_len = 4'd7;
        run_seq(4, 8, 13);
        chk(n_valid == 4, "R3 four reads with long pulse", n_valid, 4);
        chk(w_min == 7 && w_max == 7, "R4 read width 7", w_max, 7);

        $display("test done: total=%0d bad=%0d", n_total, n_bad);
        $finish;
    end

endmodule